// File: doc/BRIEF.md
# I2C Bus Occupancy and Arbitration Monitor

This block sits beside an I2C controller and watches the two open-drain lines after they pass through a synchronizer. It reports whether some master currently owns the bus, and it emits one-cycle pulses when a START or a STOP appears on the wire. It also emits a pulse on the cycle the bus returns to idle.

The block also decides when the controller has lost arbitration. This is not limited to a wire mismatch. A mismatch counts when the controller releases SDA high but reads it low on a rising SCL, while it is a master in a transmit bit or in the acknowledge slot of a receive byte. Three procedural faults also count:
- a fresh start requested while the bus is owned;
- a repeated start requested while acting as a slave;
- a STOP seen while acting as a master without having asked for one.

The controller supplies its own phase and mode flags and its requests as single-cycle strobes. It reacts to the arbitration pulse by releasing the lines.

An optional filter per line suppresses short disturbances before edge detection. Clock generation, shifting and the register interface belong to the surrounding controller.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After reset `busy_o` is 0 and `start_o`, `stop_o`, `idle_o`, `arb_lost_o` are all 0.
- R2: A falling SDA while SCL is high gives a single-cycle `start_o` pulse. The pulse is high in the cycle that follows the SYNC_STAGES+DEGLITCH-th rising clock edge after the change. `busy_o` is 1 from the next cycle on.
- R3: A rising SDA while SCL is high gives a single-cycle `stop_o` pulse with the same latency as R2. `busy_o` is 0 from the next cycle on.
- R4: An SDA change while SCL is low, or an SCL change with SDA steady, produces neither `start_o` nor `stop_o` and leaves `busy_o` unchanged.
- R5: `idle_o` pulses for one cycle, in the first cycle where `busy_o` is 0 after being 1. A STOP seen while `busy_o` is already 0 gives no `idle_o`.
- R6: With `is_master_i`=1, `tx_phase_i`=1 and `sda_drive_hi_i`=1, a synchronized rising SCL that finds SDA low gives an `arb_lost_o` pulse one cycle after the rise is detected.
- R7: The same mismatch during `rx_ack_phase_i`=1 (master, driving high) also gives an `arb_lost_o` pulse.
- R8: `start_req_i` sampled high while `busy_o`=1 gives an `arb_lost_o` pulse on the next cycle. With `busy_o`=0 it has no effect.
- R9: `rstart_req_i` sampled high with `is_master_i`=0 (slave mode) gives an `arb_lost_o` pulse on the next cycle. With `is_master_i`=1 it has no effect.
- R10: A STOP detected while `is_master_i`=1 gives an `arb_lost_o` pulse unless `stop_req_i` was strobed since the last STOP. A requested STOP, or any STOP in slave mode, gives none.
- R11: On a rising SCL, the mismatch rule fires exactly when master AND driving-high AND SDA-low AND (transmit OR ack phase). Each `arb_lost_o` pulse lasts one cycle.
- R12: With DEGLITCH>0, a level change that lasts fewer than DEGLITCH synchronized cycles never reaches the detectors. A change lasting longer passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Resolved SCL line level |
| sda_i | input | 1 | Resolved SDA line level |
| sda_drive_hi_i | input | 1 | 1 when the controller releases SDA (intends high) |
| is_master_i | input | 1 | 1 in master mode, 0 in slave mode |
| tx_phase_i | input | 1 | Controller is in an address or data transmit bit |
| rx_ack_phase_i | input | 1 | Controller is in the acknowledge slot of a received byte |
| start_req_i | input | 1 | Strobe: controller asks for a fresh start |
| rstart_req_i | input | 1 | Strobe: controller asks for a repeated start |
| stop_req_i | input | 1 | Strobe: controller asks for a stop |
| busy_o | output | 1 | Bus owned between START and STOP |
| start_o | output | 1 | One-cycle START seen |
| stop_o | output | 1 | One-cycle STOP seen |
| idle_o | output | 1 | One-cycle pulse when the bus goes from busy to idle |
| arb_lost_o | output | 1 | One-cycle arbitration-lost pulse |

## Verification
The bench builds the main instance with SYNC_STAGES=2 and DEGLITCH=0. The total latency is then two edges, so every pulse edge can be checked cycle-exactly.

It then sweeps all 32 combinations of mode, both phase flags, drive intent and SDA level across an SCL rise. It compares the pulse count against the product term worked out in the bench.

A second instance with DEGLITCH=3 shares the same stimulus. It shows that a two-cycle SDA dip is absorbed while a five-cycle dip yields exactly one START.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

   // One sample of the two bus wires after conditioning
   typedef struct packed {
      logic scl;
      logic sda;
   } i2c_lines_t;

   // Index of each arbitration-loss reason inside the cause vector
   typedef enum int unsigned {
      CAUSE_BIT_MISMATCH = 0,
      CAUSE_ACK_MISMATCH = 1,
      CAUSE_START_BUSY   = 2,
      CAUSE_RSTART_SLAVE = 3,
      CAUSE_STOP_UNREQ   = 4
   } arb_cause_e;

   localparam int unsigned NUM_CAUSES = 5;

   // Idle level of an open-drain line
   localparam logic LINE_IDLE = 1'b1;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DEGLITCH    = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   import i2c_mon_pkg::*;

   localparam int unsigned CNT_W = (DEGLITCH < 2) ? 1 : $clog2(DEGLITCH);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("i2c_line_sync: SYNC_STAGES must be at least 2");
   end
   if (DEGLITCH > 255) begin : g_bad_filter
      $error("i2c_line_sync: DEGLITCH must not exceed 255");
   end

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {SYNC_STAGES{LINE_IDLE}};
      else        chain_q <= {chain_q[SYNC_STAGES-2:0], line_i};
   end

   assign synced = chain_q[SYNC_STAGES-1];

   if (DEGLITCH == 0) begin : g_direct
      assign line_o = synced;
   end else begin : g_filter
      logic             held_q;
      logic [CNT_W-1:0] run_q;
      logic             differs;
      logic             run_done;

      assign differs  = (synced != held_q);
      assign run_done = (run_q == CNT_W'(DEGLITCH - 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            held_q <= LINE_IDLE;
            run_q  <= '0;
         end else if (!differs) begin
            run_q  <= '0;
         end else if (run_done) begin
            held_q <= synced;
            run_q  <= '0;
         end else begin
            run_q  <= run_q + 1'b1;
         end
      end

      assign line_o = held_q;
   end

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
   input  logic                     clk,
   input  logic                     rst_n,
   input  i2c_mon_pkg::i2c_lines_t  now_i,
   output logic                     start_det_o,
   output logic                     stop_det_o,
   output logic                     scl_rise_o
);
   import i2c_mon_pkg::*;

   i2c_lines_t prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '{scl: LINE_IDLE, sda: LINE_IDLE};
      else        prev_q <= now_i;
   end

   logic scl_held_high;
   assign scl_held_high = now_i.scl & prev_q.scl;

   assign start_det_o = scl_held_high &  prev_q.sda & ~now_i.sda;
   assign stop_det_o  = scl_held_high & ~prev_q.sda &  now_i.sda;
   assign scl_rise_o  = now_i.scl & ~prev_q.scl;

endmodule

// File: rtl/i2c_busy_track.sv
module i2c_busy_track (
   input  logic clk,
   input  logic rst_n,
   input  logic start_det_i,
   input  logic stop_det_i,
   output logic busy_o,
   output logic idle_o
);
   logic busy_q;
   logic idle_q;
   logic busy_d;

   always_comb begin
      busy_d = busy_q;
      if (start_det_i)     busy_d = 1'b1;
      else if (stop_det_i) busy_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idle_q <= 1'b0;
      end else begin
         busy_q <= busy_d;
         idle_q <= busy_q & ~busy_d;
      end
   end

   assign busy_o = busy_q;
   assign idle_o = idle_q;

endmodule

// File: rtl/i2c_arb_check.sv
module i2c_arb_check (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_rise_i,
   input  logic sda_now_i,
   input  logic stop_det_i,
   input  logic busy_i,
   input  logic sda_drive_hi_i,
   input  logic is_master_i,
   input  logic tx_phase_i,
   input  logic rx_ack_phase_i,
   input  logic start_req_i,
   input  logic rstart_req_i,
   input  logic stop_req_i,
   output logic arb_lost_o
);
   import i2c_mon_pkg::*;

   logic [NUM_CAUSES-1:0] cause;
   logic                  stop_owed_q;
   logic                  lost_q;
   logic                  wire_conflict;

   // Line reads low although this controller released it, on an SCL rise
   assign wire_conflict = scl_rise_i & is_master_i & sda_drive_hi_i & ~sda_now_i;

   always_comb begin
      cause                     = '0;
      cause[CAUSE_BIT_MISMATCH] = wire_conflict & tx_phase_i;
      cause[CAUSE_ACK_MISMATCH] = wire_conflict & rx_ack_phase_i;
      cause[CAUSE_START_BUSY]   = start_req_i & busy_i;
      cause[CAUSE_RSTART_SLAVE] = rstart_req_i & ~is_master_i;
      cause[CAUSE_STOP_UNREQ]   = stop_det_i & is_master_i & ~stop_owed_q;
   end

   // Remembers that a stop was asked for until one is seen on the wire
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          stop_owed_q <= 1'b0;
      else if (stop_det_i) stop_owed_q <= 1'b0;
      else if (stop_req_i) stop_owed_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lost_q <= 1'b0;
      else        lost_q <= |cause;
   end

   assign arb_lost_o = lost_q;

endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DEGLITCH    = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   input  logic sda_drive_hi_i,
   input  logic is_master_i,
   input  logic tx_phase_i,
   input  logic rx_ack_phase_i,
   input  logic start_req_i,
   input  logic rstart_req_i,
   input  logic stop_req_i,
   output logic busy_o,
   output logic start_o,
   output logic stop_o,
   output logic idle_o,
   output logic arb_lost_o
);
   import i2c_mon_pkg::*;

   localparam int unsigned NUM_LINES = 2;

   logic [NUM_LINES-1:0] raw_lines;
   logic [NUM_LINES-1:0] clean_lines;
   i2c_lines_t           lines_now;
   logic                 start_det;
   logic                 stop_det;
   logic                 scl_rise;

   assign raw_lines = {scl_i, sda_i};

   for (genvar li = 0; li < NUM_LINES; li++) begin : g_line
      i2c_line_sync #(
         .SYNC_STAGES (SYNC_STAGES),
         .DEGLITCH    (DEGLITCH)
      ) u_sync (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (raw_lines[li]),
         .line_o (clean_lines[li])
      );
   end

   assign lines_now = '{scl: clean_lines[1], sda: clean_lines[0]};

   i2c_cond_detect u_cond (
      .clk         (clk),
      .rst_n       (rst_n),
      .now_i       (lines_now),
      .start_det_o (start_det),
      .stop_det_o  (stop_det),
      .scl_rise_o  (scl_rise)
   );

   i2c_busy_track u_busy (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_det_i (start_det),
      .stop_det_i  (stop_det),
      .busy_o      (busy_o),
      .idle_o      (idle_o)
   );

   i2c_arb_check u_arb (
      .clk            (clk),
      .rst_n          (rst_n),
      .scl_rise_i     (scl_rise),
      .sda_now_i      (lines_now.sda),
      .stop_det_i     (stop_det),
      .busy_i         (busy_o),
      .sda_drive_hi_i (sda_drive_hi_i),
      .is_master_i    (is_master_i),
      .tx_phase_i     (tx_phase_i),
      .rx_ack_phase_i (rx_ack_phase_i),
      .start_req_i    (start_req_i),
      .rstart_req_i   (rstart_req_i),
      .stop_req_i     (stop_req_i),
      .arb_lost_o     (arb_lost_o)
   );

   assign start_o = start_det;
   assign stop_o  = stop_det;

endmodule

// File: rtl/i2c_bus_monitor_chk.sv
module i2c_bus_monitor_chk (
   input logic clk,
   input logic rst_n,
   input logic is_master_i,
   input logic start_req_i,
   input logic rstart_req_i,
   input logic busy_o,
   input logic start_o,
   input logic stop_o,
   input logic idle_o,
   input logic arb_lost_o
);

   p_busy_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> busy_o);

   p_busy_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stop_o |=> !busy_o);

   p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_o && !stop_o) |=> $stable(busy_o));

   p_no_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_o && stop_o));

   p_idle_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      idle_o |-> (!busy_o && $past(busy_o)));

   p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req_i && busy_o) |=> arb_lost_o);

   p_rstart_slave_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rstart_req_i && !is_master_i) |=> arb_lost_o);

endmodule

bind i2c_bus_monitor i2c_bus_monitor_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .is_master_i  (is_master_i),
   .start_req_i  (start_req_i),
   .rstart_req_i (rstart_req_i),
   .busy_o       (busy_o),
   .start_o      (start_o),
   .stop_o       (stop_o),
   .idle_o       (idle_o),
   .arb_lost_o   (arb_lost_o)
);

// File: tb/i2c_bus_monitor_tb.sv
`timescale 1ns/1ps
module i2c_bus_monitor_tb;

   localparam int unsigned SYNC_STAGES = 2;
   localparam int unsigned DEGLITCH_F  = 3;
   localparam int unsigned LAT         = SYNC_STAGES;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1, sda = 1'b1;
   logic drv_hi = 1'b0, master = 1'b0, txp = 1'b0, ackp = 1'b0;
   logic sreq = 1'b0, rsreq = 1'b0, preq = 1'b0;

   logic busy, start, stop, idle, arb;
   logic busy_f, start_f, stop_f, idle_f, arb_f;

   int n_checks = 0;
   int n_fail   = 0;
   int c_start = 0, c_stop = 0, c_idle = 0, c_arb = 0, c_start_f = 0;

   always #2.5 clk = ~clk;

   i2c_bus_monitor #(.SYNC_STAGES(SYNC_STAGES), .DEGLITCH(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
      .sda_drive_hi_i(drv_hi), .is_master_i(master), .tx_phase_i(txp),
      .rx_ack_phase_i(ackp), .start_req_i(sreq), .rstart_req_i(rsreq),
      .stop_req_i(preq), .busy_o(busy), .start_o(start), .stop_o(stop),
      .idle_o(idle), .arb_lost_o(arb));

   i2c_bus_monitor #(.SYNC_STAGES(SYNC_STAGES), .DEGLITCH(DEGLITCH_F)) u_dut_flt (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
      .sda_drive_hi_i(drv_hi), .is_master_i(master), .tx_phase_i(txp),
      .rx_ack_phase_i(ackp), .start_req_i(sreq), .rstart_req_i(rsreq),
      .stop_req_i(preq), .busy_o(busy_f), .start_o(start_f), .stop_o(stop_f),
      .idle_o(idle_f), .arb_lost_o(arb_f));

   // Pulse counters, sampled mid-cycle
   always @(negedge clk) begin
      if (start)   c_start++;
      if (stop)    c_stop++;
      if (idle)    c_idle++;
      if (arb)     c_arb++;
      if (start_f) c_start_f++;
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic clr();
      c_start = 0; c_stop = 0; c_idle = 0; c_arb = 0; c_start_f = 0;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic pulse_req(ref logic r);
      r = 1'b1; step(1); r = 1'b0; step(3);
   endtask

   initial begin
      #100000;
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      step(4);
      rst_n = 1'b1;
      step(2);
      // R1 reset state
      chk("R1 busy", busy, 0);
      chk("R1 pulses", {start, stop, idle, arb}, 0);

      // R2 exact START latency
      clr();
      sda = 1'b0;
      step(LAT - 1);
      chk("R2 early", start, 0);
      step(1);
      chk("R2 start pulse", start, 1);
      chk("R2 busy not yet", busy, 0);
      step(1);
      chk("R2 start ends", start, 0);
      chk("R2 busy set", busy, 1);

      // R4 SDA toggles with SCL low, SCL toggles with SDA steady
      clr();
      scl = 1'b0; step(4);
      sda = 1'b1; step(4);
      sda = 1'b0; step(4);
      scl = 1'b1; step(4);
      chk("R4 no start/stop", c_start + c_stop, 0);
      chk("R4 busy kept", busy, 1);

      // R3/R5 exact STOP latency in slave mode (R10: slave stop is no loss)
      clr();
      sda = 1'b1;
      step(LAT);
      chk("R3 stop pulse", stop, 1);
      chk("R5 no idle yet", idle, 0);
      step(1);
      chk("R3 stop ends", stop, 0);
      chk("R3 busy clear", busy, 0);
      chk("R5 idle pulse", idle, 1);
      step(1);
      chk("R5 idle ends", idle, 0);
      step(3);
      chk("R10 slave stop no arb", c_arb, 0);

      // R5 STOP while already idle gives no idle pulse
      clr();
      scl = 1'b0; step(3); sda = 1'b0; step(3);
      scl = 1'b1; step(4); sda = 1'b1; step(5);
      chk("R5 stop seen", c_stop, 1);
      chk("R5 no idle when idle", c_idle, 0);

      // R8 start request
      clr();
      pulse_req(sreq);
      chk("R8 start req idle", c_arb, 0);
      sda = 1'b0; step(5);
      chk("R8 busy", busy, 1);
      clr();
      sreq = 1'b1; step(1); sreq = 1'b0;
      chk("R8 arb pulse", arb, 1);
      step(1);
      chk("R11 arb one cycle", arb, 0);
      step(2);
      chk("R8 count", c_arb, 1);

      // R9 repeated start request
      clr();
      master = 1'b0; pulse_req(rsreq);
      chk("R9 slave rstart", c_arb, 1);
      clr();
      master = 1'b1; pulse_req(rsreq);
      chk("R9 master rstart", c_arb, 0);

      // R10 unrequested STOP in master mode (bus busy, SCL high, SDA low)
      clr();
      sda = 1'b1; step(LAT);
      chk("R10 stop", stop, 1);
      step(1);
      chk("R10 unrequested arb", arb, 1);
      step(3);
      chk("R10 count", c_arb, 1);
      // requested STOP
      sda = 1'b0; step(5);
      clr();
      pulse_req(preq);
      sda = 1'b1; step(6);
      chk("R10 requested stop", c_stop, 1);
      chk("R10 requested no arb", c_arb, 0);
      chk("R5 idle on requested stop", c_idle, 1);

      // R6/R7/R11 sweep over mode, phases, drive intent and SDA level
      for (int v = 0; v < 32; v++) begin
         int exp;
         scl = 1'b0; step(6);
         clr();
         master = v[0]; txp = v[1]; ackp = v[2]; drv_hi = v[3]; sda = v[4];
         step(6);
         scl = 1'b1; step(6);
         scl = 1'b0; step(6);
         exp = (v[0] & v[3] & ~v[4] & (v[1] | v[2])) ? 1 : 0;
         if (v[1] && !v[2]) chk("R6 tx sweep", c_arb, exp);
         else if (v[2] && !v[1]) chk("R7 ack sweep", c_arb, exp);
         else chk("R11 sweep", c_arb, exp);
         chk("R4 sweep no cond", c_start + c_stop, 0);
      end
      master = 1'b0; txp = 1'b0; ackp = 1'b0; drv_hi = 1'b0;

      // R12 filter: short dip absorbed, long dip passes
      sda = 1'b1; step(4); scl = 1'b1; step(12);
      clr();
      sda = 1'b0; step(2); sda = 1'b1; step(12);
      chk("R12 short dip filtered", c_start_f, 0);
      chk("R12 short dip unfiltered", c_start, 1);
      clr();
      sda = 1'b0; step(5); sda = 1'b1; step(12);
      chk("R12 long dip passes", c_start_f, 1);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule